// File: doc/BRIEF.md
# Auto-Reload Decrementer Timer

A down-counter for use as a general-purpose software timer. The counter loses one count on every clock cycle in which the timebase tick input is high. It has no run or stop control, so it counts whenever the block is clocked. When a tick takes the counter from one to zero, the block sets a sticky pending flag. The interrupt request output is that flag gated by an interrupt enable. Software clears the flag by pulsing a clear strobe, which stands for writing a one to the status bit.

A separate reload register holds a period value. While auto-reload is enabled, the expiry tick copies the reload value into the counter, so the timer runs periodically. While auto-reload is disabled, the counter settles at zero and stays there. Software may overwrite the counter in any cycle, and that write takes precedence over a tick in the same cycle.

Top module: `dec_timer`

## Requirements
- R1: After reset the counter reads CNT_RESET (default 0), the reload register reads RLD_RESET (default 0), and the pending flag and the interrupt request are low.
- R2: In a cycle with `tick_i` high, no counter write and a count above 1, the count falls by exactly one at the next edge. In a cycle with `tick_i` low and no write, the count is unchanged.
- R3: A tick taken while the count is 1 (with no counter write in that cycle) is an expiry event. `pend_o` is high from the next edge.
- R4: On an expiry event with `autoreload_i` high, the counter takes the reload register's value as it stood before that edge. A reload write in the same cycle only affects later expiries.
- R5: On an expiry event with `autoreload_i` low, the counter becomes 0. A counter at 0 stays at 0 on further ticks, whatever `autoreload_i` is, and signals no further events.
- R6: A counter write (`cnt_wr_i`) loads `cnt_wdata_i` at the next edge and overrides a tick in the same cycle. Writing 0 does not set `pend_o`.
- R7: A reload write (`rld_wr_i`) loads `rld_wdata_i` into the reload register at the next edge and leaves the counter untouched.
- R8: `pend_o` stays high until a cycle with `pend_clr_i` high, and is low after that edge. A clear strobe while the flag is already low leaves it low.
- R9: When an expiry event and a clear strobe fall in the same cycle, `pend_o` is high after the edge.
- R10: `irq_o` equals `pend_o` AND `irq_en_i` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick, one decrement per cycle high |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | WIDTH | Counter write value |
| rld_wr_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | WIDTH | Reload register write value |
| autoreload_i | input | 1 | Reload on expiry when high, stop at zero when low |
| irq_en_i | input | 1 | Interrupt enable |
| pend_clr_i | input | 1 | Clear strobe for the pending flag (write-one-to-clear) |
| cnt_o | output | WIDTH | Current count |
| rld_o | output | WIDTH | Current reload value |
| pend_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are cycles where several sources act on the same edge. These include an expiry tick that coincides with a clear strobe or with a reload write, and a counter write that lands on a tick. The bench reaches them by writing the counter to 1 and then scheduling the tick together with the competing strobe in a single cycle. It also runs long stretches of sparse random ticks, writes and clears against a behavioural model, so that expiry, settling at zero and reloading recur under many enable combinations.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
   // action chosen for the counter on the coming edge
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_DEC    = 2'd1,
      ACT_LOAD   = 2'd2,
      ACT_EXPIRE = 2'd3
   } cnt_act_e;
endpackage

// File: rtl/dtmr_reload.sv
module dtmr_reload #(
   parameter int unsigned WIDTH = 32,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] val_o
);
   logic [WIDTH-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= RST_VAL;
      else if (wr_i) val_q <= wdata_i;
   end

   assign val_o = val_q;

   // R7: a write lands at the next edge
   a_r7_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> val_o == $past(wdata_i));
endmodule

// File: rtl/dtmr_count.sv
module dtmr_count
   import dtmr_pkg::*;
#(
   parameter int unsigned WIDTH = 32,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             autoreload_i,
   input  logic [WIDTH-1:0] reload_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             expire_o
);
   localparam logic [WIDTH-1:0] CNT_ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] CNT_ZERO = '0;

   cnt_act_e         act;
   logic [WIDTH-1:0] cnt_q, cnt_d;

   always_comb begin
      if (wr_i)                   act = ACT_LOAD;
      else if (!tick_i)           act = ACT_HOLD;
      else if (cnt_q == CNT_ONE)  act = ACT_EXPIRE;
      else if (cnt_q == CNT_ZERO) act = ACT_HOLD;
      else                        act = ACT_DEC;
   end

   always_comb begin
      unique case (act)
         ACT_DEC:    cnt_d = cnt_q - CNT_ONE;
         ACT_LOAD:   cnt_d = wdata_i;
         ACT_EXPIRE: cnt_d = autoreload_i ? reload_i : CNT_ZERO;
         default:    cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= RST_VAL;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o    = cnt_q;
   assign expire_o = (act == ACT_EXPIRE);

   // R2: no tick and no write keeps the count
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_i) |=> $stable(cnt_o));
   // R5: zero is a resting state without auto-reload escape
   a_r5_rest_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && cnt_o == CNT_ZERO) |=> cnt_o == CNT_ZERO);
   // R6: a write beats a tick
   a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> cnt_o == $past(wdata_i));
   // R4: expiry with auto-reload copies the old reload value
   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !wr_i && autoreload_i && cnt_o == CNT_ONE) |=> cnt_o == $past(reload_i));
endmodule

// File: rtl/dtmr_status.sv
module dtmr_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic irq_en_i,
   output logic pend_o,
   output logic irq_o
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_q <= 1'b0;
      else if (set_i) pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
   end

   assign pend_o = pend_q;
   assign irq_o  = pend_q & irq_en_i;

   // R8: sticky until cleared
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !clr_i) |=> pend_o);
   // R9: set dominates clear
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> pend_o);
endmodule

// File: rtl/dec_timer.sv
module dec_timer #(
   parameter int unsigned WIDTH = 32,
   parameter logic [WIDTH-1:0] CNT_RESET = '0,
   parameter logic [WIDTH-1:0] RLD_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             cnt_wr_i,
   input  logic [WIDTH-1:0] cnt_wdata_i,
   input  logic             rld_wr_i,
   input  logic [WIDTH-1:0] rld_wdata_i,
   input  logic             autoreload_i,
   input  logic             irq_en_i,
   input  logic             pend_clr_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic [WIDTH-1:0] rld_o,
   output logic             pend_o,
   output logic             irq_o
);
   localparam logic [WIDTH-1:0] TOP_ONE = WIDTH'(1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dec_timer: WIDTH must be at least 2");
      end
   endgenerate

   logic             expire;
   logic [WIDTH-1:0] reload_val;

   dtmr_reload #(.WIDTH(WIDTH), .RST_VAL(RLD_RESET)) i_reload (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (rld_wr_i),
      .wdata_i (rld_wdata_i),
      .val_o   (reload_val)
   );

   dtmr_count #(.WIDTH(WIDTH), .RST_VAL(CNT_RESET)) i_count (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .wr_i         (cnt_wr_i),
      .wdata_i      (cnt_wdata_i),
      .autoreload_i (autoreload_i),
      .reload_i     (reload_val),
      .cnt_o        (cnt_o),
      .expire_o     (expire)
   );

   dtmr_status i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (expire),
      .clr_i    (pend_clr_i),
      .irq_en_i (irq_en_i),
      .pend_o   (pend_o),
      .irq_o    (irq_o)
   );

   assign rld_o = reload_val;

   // R3: tick at one raises the flag
   a_r3_expiry_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !cnt_wr_i && cnt_o == TOP_ONE) |=> pend_o);
   // R6: a write never raises the flag by itself
   a_r6_write_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_i && !pend_o) |=> !pend_o);
   // R5: without auto-reload an expiry ends at zero
   a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !cnt_wr_i && !autoreload_i && cnt_o == TOP_ONE) |=> cnt_o == '0);
endmodule

// File: tb/test_dec_timer.sv
module test_dec_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 0, cwr = 0, rwr = 0, ar = 0, ien = 0, clr = 0;
   logic [31:0] cdat = '0, rdat = '0;
   logic [31:0] cnt, rld;
   logic        pend, irq;

   int          n_chk = 0, n_bad = 0;
   bit          done = 0;

   // reference state
   logic [31:0] m_cnt = '0, m_rld = '0;
   bit          m_pend = 0;

   always #5 clk = ~clk;

   dec_timer i_dec_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_wr_i(cwr), .cnt_wdata_i(cdat),
      .rld_wr_i(rwr), .rld_wdata_i(rdat), .autoreload_i(ar), .irq_en_i(ien),
      .pend_clr_i(clr), .cnt_o(cnt), .rld_o(rld), .pend_o(pend), .irq_o(irq)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // drive one cycle: apply inputs, compare against model, advance model
   task automatic cyc(string tag, bit t, bit cw, logic [31:0] cd, bit rw, logic [31:0] rd,
                      bit a, bit ie, bit c);
      bit          ev;
      logic [31:0] nc;
      tick = t; cwr = cw; cdat = cd; rwr = rw; rdat = rd; ar = a; ien = ie; clr = c;
      #1;
      chk(tag, "cnt", cnt, m_cnt);
      chk(tag, "rld", rld, m_rld);
      chk(tag, "pend", {31'b0, pend}, {31'b0, m_pend});
      chk({tag, "/R10"}, "irq", {31'b0, irq}, {31'b0, m_pend & ie});
      ev = !cw && t && (m_cnt == 1);
      nc = m_cnt;
      if (cw)                 nc = cd;
      else if (ev)            nc = a ? m_rld : 0;
      else if (t && m_cnt != 0) nc = m_cnt - 1;
      m_cnt = nc;
      if (rw) m_rld = rd;
      if (ev)     m_pend = 1;
      else if (c) m_pend = 0;
      @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      chk("R1", "cnt", cnt, 0);
      chk("R1", "rld", rld, 0);
      chk("R1", "pend", {31'b0, pend}, 0);
      chk("R1", "irq", {31'b0, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 load 5, R2 sparse ticks
      cyc("R6", 0, 1, 5, 0, 0, 0, 1, 0);
      for (int i = 0; i < 12; i++) cyc("R2", i % 3 == 0, 0, 0, 0, 0, 0, 1, 0);
      // R3/R5 expiry without reload, then rest at zero under ticks
      for (int i = 0; i < 6; i++) cyc("R5", 1, 0, 0, 0, 0, i > 2, 1, 0);
      // R10 enable toggled while pending
      cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R10", 0, 0, 0, 0, 0, 0, 1, 0);
      // R8 clear, then clear again while low
      cyc("R8", 0, 0, 0, 0, 0, 0, 1, 1);
      cyc("R8", 0, 0, 0, 0, 0, 0, 1, 1);
      cyc("R8", 0, 0, 0, 0, 0, 0, 1, 0);
      // R6 write zero sets nothing
      cyc("R6", 1, 1, 0, 0, 0, 0, 1, 0);
      cyc("R6", 1, 0, 0, 0, 0, 0, 1, 0);
      // R7 reload write leaves counter
      cyc("R7", 0, 1, 9, 0, 0, 1, 1, 0);
      cyc("R7", 1, 0, 0, 1, 3, 1, 1, 0);
      cyc("R7", 0, 0, 0, 0, 0, 1, 1, 0);
      // R4 periodic reload: write 1, tick expiry, reload write same cycle
      cyc("R4", 0, 1, 1, 0, 0, 1, 1, 1);
      cyc("R4", 1, 0, 0, 1, 7, 1, 1, 0);
      for (int i = 0; i < 4; i++) cyc("R4", 1, 0, 0, 0, 0, 1, 1, 0);
      cyc("R4", 0, 0, 0, 0, 0, 1, 1, 1);
      for (int i = 0; i < 10; i++) cyc("R4", 1, 0, 0, 0, 0, 1, 1, 0);
      // R6 write overrides tick
      cyc("R6", 1, 1, 2, 0, 0, 1, 1, 0);
      // R9 clear with expiry in same cycle
      cyc("R9", 1, 0, 0, 0, 0, 0, 1, 1);
      cyc("R9", 1, 0, 0, 0, 0, 0, 1, 1);
      cyc("R9", 0, 0, 0, 0, 0, 0, 1, 0);
      // R2 random mix against the model
      for (int i = 0; i < 3000; i++) begin
         cyc("R2", ($urandom % 3) == 0, ($urandom % 40) == 0, $urandom % 6,
             ($urandom % 50) == 0, $urandom % 5, ($urandom % 4) != 0,
             ($urandom % 2) == 0, ($urandom % 9) == 0);
      end
      summary();
   end
endmodule